// File: doc/BRIEF.md
# Justified conversion result register with byte-read lock

This block keeps the most recent 10-bit converter result and shows it to a host as two 8-bit bytes, an upper byte and a lower byte, taken from a 16-bit view of the result. An alignment input chooses whether the result sits at the top of that view (left alignment, so the upper byte alone carries the eight most significant result bits) or at the bottom (right alignment, a plain zero-extended number). Alignment is applied on the output path, so flipping it re-maps the stored value at once without waiting for another conversion.

Reading a wide value through a narrow port needs two reads, and a new result landing between them would mix bytes of two different samples. To avoid that, a read of the lower byte closes the register to new results. The following read of the upper byte opens it again. While it is closed, the result input is not ready and any result offered is dropped, not held: the producer is a converter that cannot stall, so the ready signal serves as an acceptance indication rather than back-pressure. A valid beat is taken only in a cycle where ready is high, and taking it raises a one-cycle completion pulse.

Top module: `adc_result_reg`

## Requirements
- R1: After reset the stored result is zero, both bytes read 0x00, the write-blocked output is low, the result input is ready and the completion pulse is low.
- R2: When res_valid and res_ready are both high at a clock edge, res_data is stored from that edge and res_done is high for exactly the following cycle.
- R3: With left_align = 1 the 16-bit view holds result bits 9..0 in view bits 15..6 with bits 5..0 zero; byte_hi is view bits 15..8 (result bits 9..2) and byte_lo is view bits 7..0.
- R4: With left_align = 0 the view holds result bits 9..0 in view bits 9..0 with bits 15..10 zero; byte_hi is view bits 15..8 and byte_lo is view bits 7..0.
- R5: A cycle with rd_lo high and rd_hi low sets the lock from the next clock edge; res_ready is low during any cycle in which rd_lo is high.
- R6: A cycle with rd_hi high clears the lock from the next clock edge; with neither read strobe high the lock keeps its value; write_blocked shows the lock.
- R7: A result offered while res_ready is low is discarded: the bytes keep showing the earlier value and res_done stays low.
- R8: Changing left_align changes byte_hi and byte_lo in the same cycle, with no new result taken.
- R9: When rd_lo and rd_hi are high in the same cycle, the lock ends up clear and no result is taken that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | A new conversion result is offered |
| res_ready | output | 1 | Result accepted this cycle if valid (low while locked or on a low-byte read) |
| res_data | input | 10 | Conversion result |
| left_align | input | 1 | 1: left-aligned view, 0: right-aligned view |
| rd_lo | input | 1 | Lower-byte read strobe |
| rd_hi | input | 1 | Upper-byte read strobe |
| byte_hi | output | 8 | Upper byte of the aligned view |
| byte_lo | output | 8 | Lower byte of the aligned view |
| write_blocked | output | 1 | Lock is set; new results are dropped |
| res_done | output | 1 | One-cycle pulse after a result is stored |

## Verification
The assertions assume the read strobes and res_valid are synchronous single-cycle-sampled levels that may arrive in any combination, including both read strobes together and a result offered while locked; they assume nothing about the order of reads. The stimulus drives all inputs on the falling edge, mixing directed sequences (lower read, blocked result, upper read, simultaneous reads, alignment flips) with long stretches of random strobes and data, so every lock transition and every discard path is crossed many times against a behavioural model.

// File: rtl/adc_rr_pkg.sv
package adc_rr_pkg;
  typedef enum logic {
    ALIGN_RIGHT = 1'b0,
    ALIGN_LEFT  = 1'b1
  } align_e;
endpackage

// File: rtl/rr_lock_ctrl.sv
module rr_lock_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_lo,
  input  logic rd_hi,
  output logic lock_o
);
  logic lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
    end else if (rd_hi) begin
      lock_q <= 1'b0;
    end else if (rd_lo) begin
      lock_q <= 1'b1;
    end
  end

  assign lock_o = lock_q;

  a_r5_lock_after_low: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lo && !rd_hi) |=> lock_o);
  a_r6_unlock_after_high: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi |=> !lock_o);
  a_r6_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_lo && !rd_hi) |=> (lock_o == $past(lock_o)));
endmodule

// File: rtl/rr_store.sv
module rr_store #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_i,
  input  logic [RES_W-1:0] data_i,
  output logic [RES_W-1:0] val_o,
  output logic             done_o
);
  logic [RES_W-1:0] val_q;
  logic             done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= cap_i;
      if (cap_i) begin
        val_q <= data_i;
      end
    end
  end

  assign val_o  = val_q;
  assign done_o = done_q;

  a_r2_store_on_capture: assert property (@(posedge clk) disable iff (!rst_n)
    cap_i |=> (done_o && val_o == $past(data_i)));
  a_r7_hold_without_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_i |=> ($stable(val_o) && !done_o));
endmodule

// File: rtl/rr_justify.sv
module rr_justify #(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic [RES_W-1:0]  val_i,
  input  logic              left_i,
  output logic [BYTE_W-1:0] hi_o,
  output logic [BYTE_W-1:0] lo_o
);
  localparam int VIEW_W = 2 * BYTE_W;
  localparam int PAD_W  = VIEW_W - RES_W;

  logic [VIEW_W-1:0] view_left;
  logic [VIEW_W-1:0] view_right;
  logic [VIEW_W-1:0] view;

  generate
    if (PAD_W == 0) begin : g_full
      assign view_left  = val_i;
      assign view_right = val_i;
    end else begin : g_pad
      assign view_left  = {val_i, {PAD_W{1'b0}}};
      assign view_right = {{PAD_W{1'b0}}, val_i};
    end
  endgenerate

  always_comb begin
    view = left_i ? view_left : view_right;
    hi_o = view[VIEW_W-1:BYTE_W];
    lo_o = view[BYTE_W-1:0];
  end
endmodule

// File: rtl/adc_result_reg.sv
module adc_result_reg #(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [RES_W-1:0]  res_data,
  input  logic              left_align,
  input  logic              rd_lo,
  input  logic              rd_hi,
  output logic [BYTE_W-1:0] byte_hi,
  output logic [BYTE_W-1:0] byte_lo,
  output logic              write_blocked,
  output logic              res_done
);
  import adc_rr_pkg::*;

  logic             lock;
  logic             capture;
  logic [RES_W-1:0] stored;
  align_e           align;

  assign align     = align_e'(left_align);
  assign res_ready = !lock && !rd_lo;
  assign capture   = res_valid && res_ready;

  rr_lock_ctrl u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_lo  (rd_lo),
    .rd_hi  (rd_hi),
    .lock_o (lock)
  );

  rr_store #(.RES_W(RES_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_i  (capture),
    .data_i (res_data),
    .val_o  (stored),
    .done_o (res_done)
  );

  rr_justify #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_just (
    .val_i  (stored),
    .left_i (align == ALIGN_LEFT),
    .hi_o   (byte_hi),
    .lo_o   (byte_lo)
  );

  assign write_blocked = lock;

  a_r7_no_accept_when_locked: assert property (@(posedge clk) disable iff (!rst_n)
    write_blocked |-> !res_ready);
  a_r9_no_accept_on_low_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo |-> !res_ready);
  a_r7_blocked_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> !res_done);
endmodule

// File: tb/adc_result_reg_bench.sv
module adc_result_reg_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       res_valid = 1'b0;
  logic       res_ready;
  logic [9:0] res_data = '0;
  logic       left_align = 1'b0;
  logic       rd_lo = 1'b0;
  logic       rd_hi = 1'b0;
  logic [7:0] byte_hi;
  logic [7:0] byte_lo;
  logic       write_blocked;
  logic       res_done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  int m_val  = 0;
  bit m_lock = 1'b0;
  bit m_done = 1'b0;

  always #10 clk = ~clk;

  adc_result_reg u_adc_result_reg (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .left_align(left_align), .rd_lo(rd_lo), .rd_hi(rd_hi),
    .byte_hi(byte_hi), .byte_lo(byte_lo), .write_blocked(write_blocked),
    .res_done(res_done)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  function automatic int exp_hi(input int v, input bit al);
    int view;
    view = al ? (v << 6) : v;
    return (view >> 8) & 8'hFF;
  endfunction

  function automatic int exp_lo(input int v, input bit al);
    int view;
    view = al ? (v << 6) : v;
    return view & 8'hFF;
  endfunction

  task automatic check_bytes(input string tag);
    chk(left_align ? {tag, " R3 hi"} : {tag, " R4 hi"}, byte_hi, exp_hi(m_val, left_align));
    chk(left_align ? {tag, " R3 lo"} : {tag, " R4 lo"}, byte_lo, exp_lo(m_val, left_align));
  endtask

  // drive on falling edge, check combinational outputs, then advance one cycle
  task automatic step(input bit v, input int d, input bit al, input bit rl, input bit rh);
    bit exp_ready;
    res_valid = v; res_data = d[9:0]; left_align = al; rd_lo = rl; rd_hi = rh;
    #1;
    exp_ready = !m_lock && !rl;
    chk(rl ? "R5 ready on low read" : "R7 ready vs lock", res_ready, exp_ready);
    check_bytes("R8 same-cycle");
    @(posedge clk);
    m_done = v && exp_ready;
    if (m_done) m_val = d & 10'h3FF;
    if (rh) m_lock = 1'b0;
    else if (rl) m_lock = 1'b1;
    @(negedge clk);
    chk("R2 done pulse", res_done, m_done);
    chk("R6 write_blocked", write_blocked, m_lock);
    check_bytes("R2 stored");
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 byte_hi", byte_hi, 0);
    chk("R1 byte_lo", byte_lo, 0);
    chk("R1 write_blocked", write_blocked, 0);
    chk("R1 res_ready", res_ready, 1);
    chk("R1 res_done", res_done, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R3: capture, left aligned
    step(1, 10'h3A5, 1, 0, 0);
    step(0, 0, 1, 0, 0);
    // R4 and R8: flip alignment without new data
    step(0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0);
    // R5: low read locks; R7: blocked results dropped
    step(0, 0, 0, 1, 0);
    step(1, 10'h011, 0, 0, 0);
    step(1, 10'h222, 1, 0, 0);
    // R6: high read unlocks, then capture works again
    step(0, 0, 1, 0, 1);
    step(1, 10'h2C3, 0, 0, 0);
    // R5: valid in the same cycle as the low read is not taken
    step(1, 10'h155, 0, 1, 0);
    step(0, 0, 0, 0, 1);
    // R9: both reads together leave the lock clear, no capture
    step(1, 10'h0FF, 1, 1, 1);
    step(0, 0, 1, 0, 0);
    // R6: high read while unlocked has no effect
    step(0, 0, 1, 0, 1);
    step(1, 10'h3FF, 1, 0, 0);
    step(1, 10'h000, 0, 0, 0);
    step(1, 10'h200, 0, 0, 0);

    // random mix of strobes, data and alignment
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom;
      step(r[0], $urandom, r[1], (r[4:2] == 3'd0), (r[7:5] == 3'd0));
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule